// File: doc/BRIEF.md
# Character-to-Segment Write Sequencer

This block is a small bus master that spreads one packed character byte across a display peripheral which stores one bit per address. A caller presents an 8-bit segment pattern and a 16-bit pointer to the top address of a digit, then pulses a start request. The sequencer issues sixteen single-cycle byte writes to descending addresses. Only bit 0 of each written byte matters to the peripheral. When the last write is out, it returns the advanced pointer, which now addresses the next digit down, together with a one-cycle done pulse.

The pattern holds the decimal point in bit 7, followed by segments a through f, with segment g in bit 0. The data path is a 9-bit register made of the pattern byte plus a carry bit that starts at zero. It rotates left through carry. It is pre-rotated twice at load and rotated once more before every write. Because of this alignment, the first eight writes land on mirror addresses with misplaced bits. Those values are harmless because the second pass overwrites them. The second eight writes place the decimal point at pointer-8 and segment g at pointer-15.

Top module: `seg_write_seq`

## Requirements
- R1: After reset, busy_o, done_o and wr_en_o are 0 and ptr_o is 0x0000.
- R2: A start_i sampled high while idle makes busy_o high from the next cycle. wr_en_o is then high for exactly 16 consecutive cycles, beginning the cycle after the start edge.
- R3: The address of write k (k = 1..16) is ptr_i - (k-1) modulo 2^16, using the pointer captured at the start edge.
- R4: Write k carries the 8 low bits of the 9-bit value {1'b0, char} rotated left by k+2 positions. For pattern 0x4E this gives 71 E2 C4 89 13 27 4E 9C 38 71 E2 C4 89 13 27 4E (hex).
- R5: For writes 9 to 16, bit 0 of the data is char bit (16-k). The decimal point therefore goes to ptr_i-8 and segment g goes to ptr_i-15.
- R6: done_o is high for exactly one cycle, the cycle after the last write, with wr_en_o low. In that cycle ptr_o equals ptr_i - 16 modulo 2^16, and ptr_o holds that value until the next accepted start.
- R7: start_i asserted while busy_o is high (including the done cycle) is ignored. Changes to char_i or ptr_i after the start edge do not alter the writes, and busy_o is low the cycle after done.
- R8: Address generation wraps modulo 2^16. A start pointer of 0x0005 produces 0x0005 down to 0xFFF6 and a returned pointer of 0xFFF5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to write one character |
| char_i | input | 8 | Packed segment pattern (DP in bit 7, g in bit 0) |
| ptr_i | input | 16 | Top address of the target digit |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ptr_o | output | 16 | Pointer after the sequence |
| wr_en_o | output | 1 | Bus write strobe |
| wr_addr_o | output | 16 | Bus write address |
| wr_data_o | output | 8 | Bus write data |

## Verification
Write k appears in the k-th cycle after the start edge, with its strobe, address and data valid together. done_o and the returned pointer are due in the 17th cycle, and busy_o must be low in the 18th. The bench drives the request on a falling edge and then steps one falling edge at a time. It compares every write against its own rotation formula and pointer arithmetic in the cycle it is due, then checks the done cycle and the idle cycle after it. Requests and input changes injected mid-sequence are checked by confirming that this timeline and these values stay unchanged.

// File: rtl/seg_seq_pkg.sv
package seg_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;

endpackage

// File: rtl/seg_rot_reg.sv
module seg_rot_reg #(
  parameter int DATA_W  = 8,
  parameter int PRE_ROT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] char_i,
  input  logic              step_i,
  output logic [DATA_W-1:0] data_o
);

  localparam int RW = DATA_W + 1;

  // one rotate-left through the carry bit (carry is the top bit)
  function automatic logic [RW-1:0] rol1(input logic [RW-1:0] v);
    return {v[RW-2:0], v[RW-1]};
  endfunction

  function automatic logic [RW-1:0] prerot(input logic [DATA_W-1:0] c);
    logic [RW-1:0] v;
    v = {1'b0, c};
    for (int i = 0; i < PRE_ROT; i++) v = rol1(v);
    return v;
  endfunction

  logic [RW-1:0] rot_q;
  logic [RW-1:0] rot_next;

  assign rot_next = rol1(rot_q);
  assign data_o   = rot_next[DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rot_q <= '0;
    else if (load_i) rot_q <= prerot(char_i);
    else if (step_i) rot_q <= rot_next;
  end

  // R4
  rot_ones_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> ($countones(rot_q) == $past($countones(rot_q))));

  // R4
  load_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> ($countones(rot_q) == $countones($past(char_i))));

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] addr_q;

  function automatic logic [ADDR_W-1:0] dec1(input logic [ADDR_W-1:0] a);
    return a - ADDR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (load_i) addr_q <= ptr_i;
    else if (step_i) addr_q <= dec1(addr_q);
  end

  assign addr_o = addr_q;

  // R3
  addr_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (addr_o + ADDR_W'(1) == $past(addr_o)));

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> $stable(addr_o));

endmodule

// File: rtl/seg_seq_ctrl.sv
module seg_seq_ctrl
  import seg_seq_pkg::*;
#(
  parameter int STEPS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);

  localparam int CNT_W = $clog2(STEPS + 1);

  seq_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              last_step;

  assign load_o    = (state_q == ST_IDLE) && start_i;
  assign step_o    = (state_q == ST_RUN);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign last_step = step_o && (cnt_q == CNT_W'(STEPS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (last_step) state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // independent write counter for the checks
  logic [CNT_W-1:0] chk_writes;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      chk_writes <= '0;
    else if (load_o) chk_writes <= '0;
    else if (step_o) chk_writes <= chk_writes + CNT_W'(1);
  end

  // R2
  write_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (chk_writes == CNT_W'(STEPS)));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> !busy_o);

  // R2
  step_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |-> busy_o && !done_o);

  // R2
  start_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> step_o);

endmodule

// File: rtl/seg_write_seq.sv
module seg_write_seq #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int PRE_ROT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] char_i,
  input  logic [ADDR_W-1:0] ptr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);

  localparam int STEPS = 2 * DATA_W;

  logic              seq_load;
  logic              seq_step;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_data;

  seg_seq_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .load_o  (seq_load),
    .step_o  (seq_step),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  seg_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (seq_load),
    .ptr_i  (ptr_i),
    .step_i (seq_step),
    .addr_o (cur_addr)
  );

  seg_rot_reg #(.DATA_W(DATA_W), .PRE_ROT(PRE_ROT)) u_rot (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (seq_load),
    .char_i (char_i),
    .step_i (seq_step),
    .data_o (cur_data)
  );

  assign wr_en_o   = seq_step;
  assign wr_addr_o = cur_addr;
  assign wr_data_o = cur_data;
  assign ptr_o     = cur_addr;

  // R6
  done_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !wr_en_o);

  // R6
  done_ptr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> $stable(ptr_o));

endmodule

// File: tb/seg_write_seq_test.sv
module seg_write_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  char_i = '0;
  logic [15:0] ptr_i = '0;
  logic        busy_o, done_o, wr_en_o;
  logic [15:0] ptr_o, wr_addr_o;
  logic [7:0]  wr_data_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  seg_write_seq uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .char_i(char_i),
    .ptr_i(ptr_i), .busy_o(busy_o), .done_o(done_o), .ptr_o(ptr_o),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  // 9-bit circular rotation of {0,char} by k+2 places
  function automatic logic [7:0] exp_byte(input logic [7:0] c, input int k);
    logic [17:0] twice;
    int r;
    r = (k + 2) % 9;
    twice = {1'b0, c, 1'b0, c};
    return twice[17 - r -: 9] [7:0];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one full character; disturb=1 injects start and input changes mid-run
  task automatic run_char(input logic [7:0] c, input logic [15:0] p, input bit disturb);
    @(negedge clk);
    start_i = 1'b1; char_i = c; ptr_i = p;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 1; k <= 16; k++) begin
      if (disturb) begin
        start_i = 1'b1; char_i = ~c; ptr_i = p ^ 16'h5A5A;
      end
      check(wr_en_o && busy_o && !done_o, "R2 strobe", {wr_en_o, busy_o, done_o}, 3'b110);
      check(wr_addr_o == p - 16'(k - 1), "R3 addr", wr_addr_o, p - 16'(k - 1));
      check(wr_data_o == exp_byte(c, k), "R4 data", wr_data_o, exp_byte(c, k));
      if (k >= 9)
        check(wr_data_o[0] == c[16 - k], "R5 segment bit", wr_data_o[0], c[16 - k]);
      @(negedge clk);
    end
    check(done_o && !wr_en_o, "R6 done", {done_o, wr_en_o}, 2'b10);
    check(ptr_o == p - 16'd16, "R6 ptr", ptr_o, p - 16'd16);
    @(negedge clk);
    start_i = 1'b0; char_i = c; ptr_i = p;
    check(!done_o && !busy_o && !wr_en_o, "R7 idle after done",
          {done_o, busy_o, wr_en_o}, 0);
    check(ptr_o == p - 16'd16, "R6 ptr held", ptr_o, p - 16'd16);
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1
    check(!busy_o && !done_o && !wr_en_o, "R1 flags", {busy_o, done_o, wr_en_o}, 0);
    check(ptr_o == 16'h0000, "R1 ptr", ptr_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 explicit example and first byte
    @(negedge clk);
    start_i = 1'b1; char_i = 8'h4E; ptr_i = 16'hC16F;
    @(negedge clk);
    start_i = 1'b0;
    check(wr_data_o == 8'h71, "R4 first byte", wr_data_o, 8'h71);
    repeat (16) @(negedge clk);
    check(ptr_o == 16'hC15F, "R6 next digit", ptr_o, 16'hC15F);
    @(negedge clk);
    run_char(8'h4E, 16'hC16F, 1'b0);
    run_char(8'hFF, 16'hC13F, 1'b0);
    run_char(8'h00, 16'hC12F, 1'b0);
    // R8 wrap
    run_char(8'hA5, 16'h0005, 1'b0);
    // R7 disturbances
    run_char(8'h3C, 16'hC16F, 1'b1);
    // idle with no start: R2 nothing issued
    repeat (3) @(negedge clk);
    check(!wr_en_o && !busy_o, "R2 no spurious write", {wr_en_o, busy_o}, 0);
    for (int n = 0; n < 24; n++) begin
      logic [7:0]  c;
      logic [15:0] p;
      c = 8'($urandom());
      p = 16'($urandom());
      run_char(c, p, n[0]);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule